// File: doc/BRIEF.md
# Four-Way Write-Back L1 Cache

This block is a single level-one cache. It can sit in front of a small processor core as either the instruction cache or the data cache. Each instance has its own core port and its own memory port, so an instruction instance and a data instance can each serve one access in the same cycle. The cache holds lines of 32 bytes in a four-way set-associative array, and the number of sets is a parameter. On every lookup it compares the tags of all four ways of the addressed set at once.

Writes that hit modify only the cached copy and mark the line dirty. Memory sees the line only when it is evicted. A write that misses first brings the whole line in and then merges the write into it. Each set keeps three bits of tree pseudo-LRU state, which pick the victim when no way is free. A miss runs as a short sequence: look up, write back the victim if it is dirty, read the new line, install it, then replay the original access so that it completes as a hit. The cache handles one request at a time and holds its ready low until the response is given.

Top module: `l1c_cache`

## Requirements
- R1: After reset, core_ready is high, mem_rd and mem_wr are low, and no line is valid. The first access to any line issues exactly one memory line read and no line write.
- R2: A read that hits returns the addressed 32-bit word on core_rdata with core_resp high in the second cycle after the accepting edge, and makes no memory transaction.
- R3: A write that hits replaces byte i of the addressed word (bits 8i+7..8i) only where core_be[i] is 1, makes no memory transaction, and leaves the line dirty.
- R4: A write that misses reads the whole line from memory and then merges the write under core_be. Later reads of that line return the merged word and the memory contents of the other words.
- R5: When the victim is valid and dirty, the cache writes the victim's full line, with its modified data, to the victim's own line address. That write completes before the line read for the new address is issued.
- R6: When the victim is clean or invalid, no line write takes place on the miss.
- R7: A free way is always taken before the pseudo-LRU choice, the lowest-numbered free way first. Four different tags in one set therefore all stay resident.
- R8: Each set has 3 replacement bits, all cleared at reset. Bit 0 picks a pair (0 selects ways 0/1, 1 selects ways 2/3). Bit 1 picks within ways 0/1 (0 selects way 0). Bit 2 picks within ways 2/3 (0 selects way 2). Every hit and every fill sets the bits on the path so that they point away from the way just used.
- R9: core_ready is low from the accepting edge until the response. Requests presented while it is low are ignored and cause neither a response nor a change of state.
- R10: A memory request stays asserted until mem_done, and line read and line write are never requested together. After a fill, the original access is replayed and hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_addr | input | ADDR_W | Byte address of the access |
| core_rd | input | 1 | Read request |
| core_wr | input | 1 | Write request (takes precedence over core_rd) |
| core_be | input | 4 | Byte enables of the write word |
| core_wdata | input | 32 | Write word |
| core_ready | output | 1 | High when a request is accepted at the next edge |
| core_resp | output | 1 | One-cycle pulse that completes an access |
| core_rdata | output | 32 | Read word, valid with core_resp |
| mem_addr | output | ADDR_W | Line-aligned address of the memory transaction |
| mem_rd | output | 1 | Line read request, held until mem_done |
| mem_wr | output | 1 | Line write request, held until mem_done |
| mem_wdata | output | 8*LINE_BYTES | Line written back |
| mem_rdata | input | 8*LINE_BYTES | Line returned, sampled with mem_done |
| mem_done | input | 1 | Completes the pending memory transaction |

## Verification
The bench builds the cache with NUM_SETS = 4 and keeps the 32-bit address and 32-byte lines. With only four sets, addresses 128 bytes apart fall into the same set, so five or six distinct tags are enough to fill a set, force evictions of both clean and dirty lines, and steer the pseudo-LRU tree into a state where its victim differs from the true least recently used line. The memory model answers after three cycles. That leaves a window during which requests can be offered while ready is low.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

  localparam int WAYS   = 4;
  localparam int WORD_W = 32;
  localparam int BE_W   = WORD_W / 8;

  typedef logic [2:0] plru_t;
  typedef logic [1:0] way_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WBACK  = 2'd2,
    ST_REFILL = 2'd3
  } cstate_t;

  // bit0: root (0 -> pair 0/1), bit1: inside 0/1, bit2: inside 2/3
  function automatic way_t plru_pick(input plru_t s);
    if (!s[0]) return s[1] ? 2'd1 : 2'd0;
    else       return s[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic plru_t plru_touch(input plru_t s, input way_t w);
    plru_t n;
    n = s;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic way_t lowest_free(input logic [WAYS-1:0] v);
    if (!v[0])      return 2'd0;
    else if (!v[1]) return 2'd1;
    else if (!v[2]) return 2'd2;
    else            return 2'd3;
  endfunction

  function automatic way_t onehot_way(input logic [WAYS-1:0] h);
    way_t w;
    w = 2'd0;
    for (int i = 0; i < WAYS; i++)
      if (h[i]) w = way_t'(i);
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] be_merge(input logic [WORD_W-1:0] old_w,
                                                 input logic [WORD_W-1:0] new_w,
                                                 input logic [BE_W-1:0]   be);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < BE_W; b++)
      r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction

endpackage

// File: rtl/l1c_tags.sv
module l1c_tags
  import l1c_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int TAG_W    = 23,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            idx,
  input  logic [TAG_W-1:0]            cmp_tag,
  output logic [WAYS-1:0]             hit_vec,
  output logic [WAYS-1:0]             valid_vec,
  output logic [WAYS-1:0]             dirty_vec,
  output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic                        fill_en,
  input  way_t                        fill_way,
  input  logic                        dirty_en,
  input  way_t                        dirty_way
);

  logic [TAG_W-1:0] tag_mem   [NUM_SETS][WAYS];
  logic [WAYS-1:0]  valid_mem [NUM_SETS];
  logic [WAYS-1:0]  dirty_mem [NUM_SETS];

  assign valid_vec = valid_mem[idx];
  assign dirty_vec = dirty_mem[idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_tag[w] = tag_mem[idx][w];
    assign hit_vec[w] = valid_mem[idx][w] && (tag_mem[idx][w] == cmp_tag);
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[idx][fill_way] <= cmp_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_mem[s] <= '0;
        dirty_mem[s] <= '0;
      end
    end else if (fill_en) begin
      valid_mem[idx][fill_way] <= 1'b1;
      dirty_mem[idx][fill_way] <= 1'b0;
    end else if (dirty_en) begin
      dirty_mem[idx][dirty_way] <= 1'b1;
    end
  end

  // R2
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R3
  dirty_after_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_en && !fill_en |=> dirty_mem[$past(idx)][$past(dirty_way)]);

endmodule

// File: rtl/l1c_data.sv
module l1c_data
  import l1c_pkg::*;
#(
  parameter int NUM_SETS   = 16,
  parameter int LINE_BYTES = 32,
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int WORDS     = LINE_BYTES / BE_W,
  localparam int WSEL_W    = $clog2(WORDS),
  localparam int ENTRIES   = NUM_SETS * WAYS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  way_t              way,
  output logic [LINE_W-1:0] line_out,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata
);

  logic [LINE_W-1:0] line_mem [ENTRIES];
  logic [IDX_W+1:0]  slot;

  assign slot     = {idx, way};
  assign line_out = line_mem[slot];

  always_ff @(posedge clk) begin
    if (fill_en)
      line_mem[slot] <= fill_line;
    else if (wr_en)
      line_mem[slot][wsel*WORD_W +: WORD_W] <=
        be_merge(line_mem[slot][wsel*WORD_W +: WORD_W], wdata, be);
  end

endmodule

// File: rtl/l1c_plru.sv
module l1c_plru
  import l1c_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int IDX_W   = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             touch_en,
  input  way_t             touch_way,
  output way_t             pick
);

  plru_t tree [NUM_SETS];

  assign pick = plru_pick(tree[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) tree[s] <= '0;
    end else if (touch_en) begin
      tree[idx] <= plru_touch(tree[idx], touch_way);
    end
  end

  // R8
  points_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> plru_pick(tree[$past(idx)]) != $past(touch_way));

endmodule

// File: rtl/l1c_cache.sv
module l1c_cache
  import l1c_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_SETS   = 16,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int WSEL_W    = OFF_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              core_rd,
  input  logic              core_wr,
  input  logic [BE_W-1:0]   core_be,
  input  logic [WORD_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_resp,
  output logic [WORD_W-1:0] core_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_done
);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] wsel_of(input logic [ADDR_W-1:0] a);
    return a[2 +: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFF_W{1'b0}}};
  endfunction

  cstate_t state;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic              wr_q;
  logic [BE_W-1:0]   be_q;
  logic [WORD_W-1:0] wdata_q;
  way_t              vic_q;
  logic              resp_q;
  logic [WORD_W-1:0] rdata_q;

  logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  way_t                       hit_way, plru_way, vic_way, rd_way;
  logic [LINE_W-1:0]          rd_line;
  logic                       vic_dirty;

  // internal events, named for the checks
  logic accept, ev_hit, ev_miss, ev_wb_done, ev_fill_done;

  assign accept       = (state == ST_IDLE) && (core_rd || core_wr);
  assign ev_hit       = (state == ST_LOOKUP) && (|hit_vec);
  assign ev_miss      = (state == ST_LOOKUP) && !(|hit_vec);
  assign ev_wb_done   = (state == ST_WBACK) && mem_done;
  assign ev_fill_done = (state == ST_REFILL) && mem_done;

  assign hit_way   = onehot_way(hit_vec);
  assign vic_way   = (&valid_vec) ? plru_way : lowest_free(valid_vec);
  assign vic_dirty = valid_vec[vic_way] && dirty_vec[vic_way];
  assign rd_way    = (state == ST_LOOKUP) ? hit_way : vic_q;

  l1c_tags #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx_q),
    .cmp_tag   (tag_q),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec),
    .way_tag   (way_tag),
    .fill_en   (ev_fill_done),
    .fill_way  (vic_q),
    .dirty_en  (ev_hit && wr_q),
    .dirty_way (hit_way)
  );

  l1c_data #(.NUM_SETS(NUM_SETS), .LINE_BYTES(LINE_BYTES)) u_data (
    .clk       (clk),
    .idx       (idx_q),
    .way       (rd_way),
    .line_out  (rd_line),
    .fill_en   (ev_fill_done),
    .fill_line (mem_rdata),
    .wr_en     (ev_hit && wr_q),
    .wsel      (wsel_q),
    .be        (be_q),
    .wdata     (wdata_q)
  );

  l1c_plru #(.NUM_SETS(NUM_SETS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx_q),
    .touch_en  (ev_hit || ev_fill_done),
    .touch_way (ev_hit ? hit_way : vic_q),
    .pick      (plru_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
      wsel_q  <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      vic_q   <= '0;
      resp_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      resp_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          tag_q   <= tag_of(core_addr);
          idx_q   <= idx_of(core_addr);
          wsel_q  <= wsel_of(core_addr);
          wr_q    <= core_wr;
          be_q    <= core_be;
          wdata_q <= core_wdata;
          state   <= ST_LOOKUP;
        end
        ST_LOOKUP: if (ev_hit) begin
          resp_q  <= 1'b1;
          rdata_q <= rd_line[wsel_q*WORD_W +: WORD_W];
          state   <= ST_IDLE;
        end else begin
          vic_q <= vic_way;
          state <= vic_dirty ? ST_WBACK : ST_REFILL;
        end
        ST_WBACK:  if (mem_done) state <= ST_REFILL;
        ST_REFILL: if (mem_done) state <= ST_LOOKUP;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign core_ready = (state == ST_IDLE);
  assign core_resp  = resp_q;
  assign core_rdata = rdata_q;
  assign mem_rd     = (state == ST_REFILL);
  assign mem_wr     = (state == ST_WBACK);
  assign mem_wdata  = rd_line;
  assign mem_addr   = (state == ST_WBACK)  ? line_addr(way_tag[vic_q], idx_q) :
                      (state == ST_REFILL) ? line_addr(tag_q, idx_q) : '0;

  // R2
  hit_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> core_resp);

  // R5
  wb_then_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> mem_rd && !mem_wr);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !core_ready && !core_resp);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_done |=> $stable(mem_addr) && (mem_rd || mem_wr));

  // R10
  replay_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_done |=> ev_hit);

  // R6
  clean_skip_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss && !vic_dirty |=> mem_rd);

endmodule

// File: tb/tb_l1c_cache.sv
module tb_l1c_cache;

  localparam int ADDR_W = 32;
  localparam int LB     = 32;
  localparam int SETS   = 4;
  localparam int LW     = LB * 8;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] core_addr = '0;
  logic core_rd = 1'b0, core_wr = 1'b0;
  logic [3:0] core_be = '0;
  logic [31:0] core_wdata = '0;
  logic core_ready, core_resp;
  logic [31:0] core_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [LW-1:0] mem_wdata;
  logic [LW-1:0] mem_rdata = '0;
  logic mem_done = 1'b0;

  always #4 clk = ~clk;

  l1c_cache #(.ADDR_W(ADDR_W), .LINE_BYTES(LB), .NUM_SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n), .core_addr(core_addr), .core_rd(core_rd),
    .core_wr(core_wr), .core_be(core_be), .core_wdata(core_wdata),
    .core_ready(core_ready), .core_resp(core_resp), .core_rdata(core_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
  );

  int n_vec = 0, n_bad = 0;
  int resp_cnt = 0;
  int n_mrd = 0, n_mwr = 0, ev_no = 0, wr_stamp = 0, rd_stamp = 0;
  int lat_cnt = 0;
  logic [ADDR_W-1:0] last_wr_addr = '0;
  logic [LW-1:0] last_wr_line = '0;

  logic [LW-1:0] bmem  [256];
  logic [31:0]   ref_w [2048];

  typedef struct { bit chk; logic [31:0] d; string req; } item_t;
  item_t exp_q [$];

  function automatic logic [31:0] init_w(input logic [31:0] a);
    return {a[15:0] ^ 16'hBEEF, a[15:0]};
  endfunction

  function automatic logic [31:0] mix(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r;
    r = o;
    if (be[0]) r[7:0]   = n[7:0];
    if (be[1]) r[15:8]  = n[15:8];
    if (be[2]) r[23:16] = n[23:16];
    if (be[3]) r[31:24] = n[31:24];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model
  always @(posedge clk) begin
    if (mem_done) mem_done <= 1'b0;
    else if (rst_n && (mem_rd || mem_wr)) begin
      if (lat_cnt == LAT - 1) begin
        lat_cnt  <= 0;
        mem_done <= 1'b1;
        ev_no    <= ev_no + 1;
        if (mem_wr) begin
          bmem[mem_addr[12:5]] <= mem_wdata;
          last_wr_addr <= mem_addr;
          last_wr_line <= mem_wdata;
          n_mwr    <= n_mwr + 1;
          wr_stamp <= ev_no + 1;
        end else begin
          mem_rdata <= bmem[mem_addr[12:5]];
          n_mrd    <= n_mrd + 1;
          rd_stamp <= ev_no + 1;
        end
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  // monitor: pops the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && core_resp) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R9: actual unexpected response %h expected none", core_rdata);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.chk) chk(it.req, core_rdata, it.d);
      end
      resp_cnt++;
    end
  end

  task automatic xfer(input bit is_wr, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input int exp_rd, input int exp_wr,
                      input string req);
    int r0, m0, w0;
    item_t it;
    r0 = resp_cnt; m0 = n_mrd; w0 = n_mwr;
    it.req = req;
    if (is_wr) begin
      ref_w[a[12:2]] = mix(ref_w[a[12:2]], wd, be);
      it.chk = 1'b0; it.d = '0;
    end else begin
      it.chk = 1'b1; it.d = ref_w[a[12:2]];
    end
    exp_q.push_back(it);
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    core_addr = a; core_rd = !is_wr; core_wr = is_wr; core_be = be; core_wdata = wd;
    @(negedge clk);
    core_rd = 1'b0; core_wr = 1'b0;
    while (resp_cnt == r0) @(negedge clk);
    if (exp_rd >= 0) chk({req, " line reads"},  n_mrd - m0, exp_rd);
    if (exp_wr >= 0) chk({req, " line writes"}, n_mwr - w0, exp_wr);
  endtask

  localparam logic [31:0] A = 32'h000, B = 32'h080, C = 32'h100, D = 32'h180,
                          E = 32'h200, F = 32'h280, G = 32'h020;

  initial begin
    for (int l = 0; l < 256; l++)
      for (int w = 0; w < 8; w++)
        bmem[l][w*32 +: 32] = init_w(32'(l * 32 + w * 4));
    for (int i = 0; i < 2048; i++) ref_w[i] = init_w(32'(i * 4));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", core_ready, 1);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 mem_wr", mem_wr, 0);
    chk("R1 resp", core_resp, 0);
    xfer(0, A + 4, 0, 0, 1, 0, "R1 cold read");
    xfer(0, A + 4, 0, 0, 0, 0, "R2 read hit");
    xfer(1, A + 8, 4'b0101, 32'h1122_3344, 0, 0, "R3 write hit");
    xfer(0, A + 8, 0, 0, 0, 0, "R3 merged read");
    xfer(1, B + 12, 4'b1100, 32'hCAFE_F00D, 1, 0, "R4 write miss");
    xfer(0, B + 12, 0, 0, 0, 0, "R4 merged word");
    xfer(0, B + 0, 0, 0, 0, 0, "R4 rest of line");
    xfer(0, C + 16, 0, 0, 1, 0, "R7 fill way2");
    xfer(0, D + 28, 0, 0, 1, 0, "R7 fill way3");
    xfer(0, A + 4, 0, 0, 0, 0, "R7 A resident");
    xfer(0, B + 12, 0, 0, 0, 0, "R7 B resident");
    xfer(0, C + 16, 0, 0, 0, 0, "R7 C resident");
    xfer(0, D + 28, 0, 0, 0, 0, "R7 D resident");
    // tree now 000 except path; touching B makes way2 (C) the victim
    xfer(0, B + 4, 0, 0, 0, 0, "R8 touch B");
    xfer(0, E + 8, 0, 0, 1, 0, "R8 R6 evict clean C");
    xfer(0, A + 8, 0, 0, 0, 0, "R8 A kept");
    xfer(0, C + 16, 0, 0, 1, 0, "R8 C refetched over D");
    // victim now way1 = B, dirty
    xfer(0, F + 20, 0, 0, 1, 1, "R5 dirty evict");
    chk("R5 wb address", last_wr_addr, B);
    chk("R5 wb data", last_wr_line[3*32 +: 32], ref_w[B[12:2] + 3]);
    chk("R5 wb before refill", 32'(wr_stamp < rd_stamp), 1);
    xfer(0, B + 12, 0, 0, 1, 0, "R5 R10 data back from memory");
    // R9: request offered while busy is ignored
    fork
      xfer(0, G + 4, 0, 0, 1, 0, "R9 cold set1");
      begin
        repeat (3) @(negedge clk);
        chk("R9 ready low in miss", core_ready, 0);
        core_addr = A + 8; core_wr = 1'b1; core_be = 4'hF; core_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        core_wr = 1'b0;
      end
    join
    repeat (4) @(negedge clk);
    chk("R9 no extra response", exp_q.size(), 0);
    xfer(0, A + 8, 0, 0, 0, 0, "R9 ignored write left A");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule